// File: doc/BRIEF.md
# Predicate Condition Evaluator

This block decides whether a predicated instruction executes. It takes a 4-bit condition field from the instruction and the current four status flags: negative, zero, carry and overflow. It returns a single `pass` bit. When `pass` is low, the pipeline turns the instruction into a no-operation. Fourteen of the sixteen codes form seven complementary pairs. Each pair tests one flag relation, and the least significant code bit selects the positive or negated sense of that relation.

Code 1110 always passes and does not look at the flags. Code 1111 depends on `arch_mode`. In legacy mode (`arch_mode`=0) the code never passes. In the newer mode (`arch_mode`=1) it passes unconditionally and raises `special_uncond`, which tells the decoder that an unconditional special instruction occupies the slot. Decoding of that special instruction happens elsewhere.

The result is registered. `pass` and `special_uncond` show the evaluation of the inputs sampled at the previous rising clock edge.

Top module: `cond_eval`

## Requirements
- R1: Code 0000 passes when Z=1 and code 0001 passes when Z=0. For any flag value, exactly one code of each pair that differs only in bit 0 passes; this covers codes 0000 through 1101.
- R2: Code 0010 (unsigned higher-or-same) passes when C=1. Code 0011 (unsigned lower) passes when C=0.
- R3: Code 0100 passes when N=1 and code 0101 passes when N=0. Code 0110 passes when V=1 and code 0111 passes when V=0.
- R4: Code 1000 (unsigned higher) passes when C=1 and Z=0. Code 1001 (unsigned lower-or-same) passes when C=0 or Z=1.
- R5: Code 1010 (signed greater-or-equal) passes when N equals V. Code 1011 (signed less) passes when N differs from V. Because the test compares N against V, an overflowed result with N=1 and V=1 still passes 1010.
- R6: Code 1100 (signed greater) passes when Z=0 and N equals V. Code 1101 (signed less-or-equal) passes when Z=1 or N differs from V.
- R7: Code 1110 passes for all sixteen flag values, and `special_uncond` stays 0.
- R8: With `arch_mode`=0, code 1111 never passes and `special_uncond` stays 0.
- R9: With `arch_mode`=1, code 1111 passes and drives `special_uncond` to 1. For every other code, `special_uncond` is 0 in either mode.
- R10: Both outputs are registered with one cycle of latency. A synchronous active-high reset forces both outputs to 0 whatever the inputs are.
- R11: Flags are packed as `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_code | input | 4 | Condition field of the instruction |
| flags | input | 4 | Status flags N, Z, C, V (bit 3 down to bit 0) |
| arch_mode | input | 1 | 0: code 1111 never executes; 1: code 1111 marks an unconditional special instruction |
| pass | output | 1 | Instruction executes (registered) |
| special_uncond | output | 1 | Code 1111 seen in newer mode (registered) |

## Verification
The bench drives every condition code against all sixteen flag combinations in both modes, back to back, so every pair is tried on both sides of its relation. Flag values with N=1 and V=1 separate a correct signed test from one that reads N alone. Flag values with Z=1 and C=1 separate the or-equal and unsigned-higher forms, because only the Z term decides those cases. Holding code 1110 during reset shows whether reset overrides an always-passing input. Running code 1111 in both modes tells the never-execute meaning apart from the special-instruction meaning.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int CODE_W = 4;
  localparam int FLAG_W = 4;
  localparam int PAIR_W = CODE_W - 1;

  // Relation tested by each code pair, indexed by code[3:1].
  typedef enum logic [PAIR_W-1:0] {
    PAIR_ZERO = 3'd0,
    PAIR_CARRY = 3'd1,
    PAIR_NEG = 3'd2,
    PAIR_OVF = 3'd3,
    PAIR_UGT = 3'd4,
    PAIR_SGE = 3'd5,
    PAIR_SGT = 3'd6,
    PAIR_ALL = 3'd7
  } pair_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/cond_pair_eval.sv
module cond_pair_eval
  import cond_pkg::*;
(
  input  logic [PAIR_W-1:0] pair_sel,
  input  nzcv_t             fl,
  output logic              base_true
);
  logic signed_ok;

  always_comb begin
    signed_ok = (fl.n == fl.v);
    unique case (pair_e'(pair_sel))
      PAIR_ZERO:  base_true = fl.z;
      PAIR_CARRY: base_true = fl.c;
      PAIR_NEG:   base_true = fl.n;
      PAIR_OVF:   base_true = fl.v;
      PAIR_UGT:   base_true = fl.c & ~fl.z;
      PAIR_SGE:   base_true = signed_ok;
      PAIR_SGT:   base_true = ~fl.z & signed_ok;
      default:    base_true = 1'b1;
    endcase
  end
endmodule

// File: rtl/cond_resolve.sv
module cond_resolve
  import cond_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              base_true,
  input  logic              mode_new,
  output logic              pass_c,
  output logic              special_c
);
  logic top_pair;

  always_comb begin
    top_pair  = (code[CODE_W-1:1] == PAIR_ALL);
    special_c = 1'b0;
    if (top_pair) begin
      if (code[0]) begin
        pass_c    = mode_new;
        special_c = mode_new;
      end else begin
        pass_c = 1'b1;
      end
    end else begin
      pass_c = base_true ^ code[0];
    end
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cond_code,
  input  logic [FLAG_W-1:0] flags,
  input  logic              arch_mode,
  output logic              pass,
  output logic              special_uncond
);
  logic  base_true;
  logic  pass_c;
  logic  special_c;
  nzcv_t fl;

  assign fl = nzcv_t'(flags);

  cond_pair_eval u_pair (
    .pair_sel  (cond_code[CODE_W-1:1]),
    .fl        (fl),
    .base_true (base_true)
  );

  cond_resolve u_res (
    .code      (cond_code),
    .base_true (base_true),
    .mode_new  (arch_mode),
    .pass_c    (pass_c),
    .special_c (special_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          pass           <= 1'b0;
          special_uncond <= 1'b0;
        end else begin
          pass           <= pass_c;
          special_uncond <= special_c;
        end
      end
    end else begin : g_comb
      assign pass           = pass_c & ~rst;
      assign special_uncond = special_c & ~rst;
    end
  endgenerate
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cond_code,
  input logic [3:0] flags,
  input logic       arch_mode,
  input logic       pass,
  input logic       special_uncond
);
  AST_EQ_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b0000) |=> (pass == $past(flags[2]))); // R1

  AST_SIGNED_GE: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1010) |=> (pass == ($past(flags[3]) == $past(flags[0])))); // R5

  AST_ALWAYS_PASS: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1110) |=> (pass && !special_uncond)); // R7

  AST_LEGACY_NEVER: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1111 && !arch_mode) |=> (!pass && !special_uncond)); // R8

  AST_SPECIAL_NEW: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1111 && arch_mode) |=> (pass && special_uncond)); // R9

  AST_SPECIAL_IMPLIES_PASS: assert property (@(posedge clk) disable iff (rst)
    special_uncond |-> pass); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!pass && !special_uncond)); // R10
endmodule

bind cond_eval cond_eval_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cond_code      (cond_code),
  .flags          (flags),
  .arch_mode      (arch_mode),
  .pass           (pass),
  .special_uncond (special_uncond)
);

// File: tb/cond_eval_tb.sv
module cond_eval_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  typedef struct {
    logic       exp_pass;
    logic       exp_sp;
    logic [3:0] code;
    logic [3:0] fl;
    logic       mode;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cond_code = 4'd0;
  logic [3:0] flags = 4'd0;
  logic       arch_mode = 1'b0;
  logic       pass;
  logic       special_uncond;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_eval u_dut (
    .clk            (clk),
    .rst            (rst),
    .cond_code      (cond_code),
    .flags          (flags),
    .arch_mode      (arch_mode),
    .pass           (pass),
    .special_uncond (special_uncond)
  );

  // Reference: R11 flag packing N=3, Z=2, C=1, V=0
  function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f, input logic m);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'b0000: return z;
      4'b0001: return !z;
      4'b0010: return cy;
      4'b0011: return !cy;
      4'b0100: return n;
      4'b0101: return !n;
      4'b0110: return v;
      4'b0111: return !v;
      4'b1000: return cy && !z;
      4'b1001: return !cy || z;
      4'b1010: return n == v;
      4'b1011: return n != v;
      4'b1100: return !z && (n == v);
      4'b1101: return z || (n != v);
      4'b1110: return 1'b1;
      default: return m;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c, input logic m);
    case (c)
      4'b0000, 4'b0001: return "R1";
      4'b0010, 4'b0011: return "R2";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R3";
      4'b1000, 4'b1001: return "R4";
      4'b1010, 4'b1011: return "R5";
      4'b1100, 4'b1101: return "R6";
      4'b1110: return "R7";
      default: return m ? "R9" : "R8";
    endcase
  endfunction

  task automatic drive(input logic [3:0] c, input logic [3:0] f, input logic m);
    item_t it;
    @(negedge clk);
    rst       = 1'b0;
    cond_code = c;
    flags     = f;
    arch_mode = m;
    it.exp_pass = ref_pass(c, f, m);
    it.exp_sp   = (c == 4'b1111) && m;
    it.code = c; it.fl = f; it.mode = m;
    it.req  = req_of(c, m);
    q.push_back(it);
  endtask

  // Monitor: compare one cycle after capture, away from the edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (pass !== it.exp_pass) begin
        errors++;
        $display("FAIL %s pass code=%b flags=%b mode=%0d actual=%b expected=%b",
                 it.req, it.code, it.fl, it.mode, pass, it.exp_pass);
      end
      checks++;
      if (special_uncond !== it.exp_sp) begin
        errors++;
        $display("FAIL %s special code=%b flags=%b mode=%0d actual=%b expected=%b",
                 (it.req == "R10") ? "R10" : "R9", it.code, it.fl, it.mode,
                 special_uncond, it.exp_sp);
      end
    end
  end

  initial begin
    item_t it;
    // R10: reset overrides an always-passing code
    @(negedge clk);
    rst = 1'b1; cond_code = 4'b1110; flags = 4'b0000; arch_mode = 1'b1;
    it.exp_pass = 1'b0; it.exp_sp = 1'b0;
    it.code = 4'b1110; it.fl = 4'b0000; it.mode = 1'b1; it.req = "R10";
    q.push_back(it);
    // Full sweep of codes, flags and modes (R1..R9, R11)
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 16; f++)
          drive(4'(c), 4'(f), 1'(m));
    // R10: reset after 1111 in the newer mode clears both outputs
    drive(4'b1111, 4'b0000, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    it.exp_pass = 1'b0; it.exp_sp = 1'b0;
    it.code = 4'b1111; it.fl = 4'b0000; it.mode = 1'b1; it.req = "R10";
    q.push_back(it);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule